// File: doc/BRIEF.md
# Legacy Interrupt Controller Bank

This block gathers 32 level-sensitive interrupt lines and presents them to two processors: a main CPU and a coprocessor. Each processor owns an enable mask and a class mask. A line that is pending and enabled for a processor drives that processor's normal request output when its class bit is 0, and its fast request output when its class bit is 1. Software can also mark any line pending by setting a sticky force bit, which stays set until it is explicitly removed.

Software reaches the bank over a simple single-cycle register bus. The bus has a byte address, write data and a write strobe, and read data that follows the address in the same cycle. The enable masks and the force mask are never written directly. They change only through write-one-to-set and write-one-to-clear alias offsets, so one store can change a group of lines without a read-modify-write. The class masks are plain read/write registers. A status offset reports which lines are currently raising the CPU fast request. All four request outputs are registered.

Top module: `lic_bank`

## Requirements
- R1: While reset is held, and after it is released, every enable, class and force bit is 0, all four request outputs are low and every readable offset returns 0.
- R2: A write to a set alias ORs the ones of the write data into its target register, and zero bits leave the target unchanged. The set aliases are 0x18 for force, 0x24 for the CPU enables and 0x34 for the coprocessor enables.
- R3: A write to a clear alias clears every target bit whose write data bit is one. The clear aliases are 0x1C for force, 0x28 for the CPU enables and 0x38 for the coprocessor enables. Writing all ones disables every line in that one write.
- R4: The class registers are read/write at 0x2C (CPU) and 0x3C (coprocessor). A class bit of 0 routes its line to the normal request, and a class bit of 1 routes it to the fast request.
- R5: Line n is pending when input bit n is high or force bit n is set. Each request output is the OR, over all lines, of pending AND that processor's enable AND the matching class value.
- R6: The request outputs are registered. A change of input lines shows on the outputs at the next rising clock edge. A register write takes effect on the edge that ends the write cycle and shows on the outputs one edge later.
- R7: A force bit stays set whatever the input line does, and only a write of one to its bit at 0x1C removes it.
- R8: Offset 0x08 reads the lines that are pending, CPU-enabled and of class 1.
- R9: Offset 0x14 reads the force mask, 0x20 the CPU enables and 0x30 the coprocessor enables. Set and clear aliases and every unmapped offset read as 0.
- R10: Writes to 0x08, 0x14, 0x20, 0x30 or any unmapped offset change no register.
- R11: The CPU and coprocessor masks are independent. A line enabled for only one processor drives only that processor's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | LINES (32) | Raw level-sensitive interrupt inputs, one per line |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | LINES (32) | Write data, one bit per line |
| bus_we | input | 1 | Write strobe for the current address |
| bus_rdata | output | LINES (32) | Read data for the current address, same cycle |
| cpu_irq | output | 1 | CPU normal request, registered |
| cpu_fiq | output | 1 | CPU fast request, registered |
| cop_irq | output | 1 | Coprocessor normal request, registered |
| cop_fiq | output | 1 | Coprocessor fast request, registered |

## Verification
The hardest case to reach from the ports is a forced line that stays pending while its raw input drops, with the forced line's class and enable also changed across the two processors. The output must then follow the force bit and not the wire, and each processor must still be routed separately. The stimulus first reaches this case on purpose: it sets a force bit with the input low, toggles the input, moves the line between classes and clears it in a single write. After that, an LFSR-driven run of writes and reads over every mapped, alias and unmapped offset keeps mixing force, enables and classes while the inputs change underneath. A behavioural model follows the bank on every cycle.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int LIC_LINES  = 32;
    localparam int LIC_ADDR_W = 8;
    localparam int LIC_NPROC  = 2;   // index 0: main CPU, index 1: coprocessor

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_FIQ_STAT,
        SEL_FRC,
        SEL_FRC_SET,
        SEL_FRC_CLR,
        SEL_CPU_EN,
        SEL_CPU_EN_SET,
        SEL_CPU_EN_CLR,
        SEL_CPU_CLS,
        SEL_COP_EN,
        SEL_COP_EN_SET,
        SEL_COP_EN_CLR,
        SEL_COP_CLS
    } lic_sel_e;

    // Byte offset to register select; offsets are fixed by the software map.
    function automatic lic_sel_e lic_decode(input logic [7:0] a);
        case (a)
            8'h08:   return SEL_FIQ_STAT;
            8'h14:   return SEL_FRC;
            8'h18:   return SEL_FRC_SET;
            8'h1C:   return SEL_FRC_CLR;
            8'h20:   return SEL_CPU_EN;
            8'h24:   return SEL_CPU_EN_SET;
            8'h28:   return SEL_CPU_EN_CLR;
            8'h2C:   return SEL_CPU_CLS;
            8'h30:   return SEL_COP_EN;
            8'h34:   return SEL_COP_EN_SET;
            8'h38:   return SEL_COP_EN_CLR;
            8'h3C:   return SEL_COP_CLS;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/lic_setclr_reg.sv
// Mask register reachable only through write-one-to-set / write-one-to-clear.
module lic_setclr_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;

    always_comb begin
        set_bits = set_we ? wdata : '0;
        clr_bits = clr_we ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q | set_bits) & ~clr_bits;
    end
endmodule

// File: rtl/lic_router.sv
// Per-processor request generation: pending lines split by class, registered.
module lic_router #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pend,
    input  logic [W-1:0] en,
    input  logic [W-1:0] cls,
    output logic         irq_o,
    output logic         fiq_o
);
    logic [W-1:0] live;

    assign live = pend & en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |(live & ~cls);
            fiq_o <= |(live & cls);
        end
    end
endmodule

// File: rtl/lic_bank.sv
module lic_bank #(
    parameter int LINES  = lic_pkg::LIC_LINES,
    parameter int ADDR_W = lic_pkg::LIC_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINES-1:0]  irq_lines,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [LINES-1:0]  bus_rdata,
    output logic              cpu_irq,
    output logic              cpu_fiq,
    output logic              cop_irq,
    output logic              cop_fiq
);
    import lic_pkg::*;

    localparam int NPROC = LIC_NPROC;

    lic_sel_e                      sel;
    logic [NPROC-1:0]              en_set_we;
    logic [NPROC-1:0]              en_clr_we;
    logic [NPROC-1:0]              cls_we;
    logic [NPROC-1:0][LINES-1:0]   en_q;
    logic [NPROC-1:0][LINES-1:0]   cls_q;
    logic [NPROC-1:0]              irq_q;
    logic [NPROC-1:0]              fiq_q;
    logic [LINES-1:0]              force_q;
    logic [LINES-1:0]              pend;
    logic                          frc_set_we;
    logic                          frc_clr_we;

    // Flat views used by the bound checker
    logic [LINES-1:0] cpu_en_q, cop_en_q, cpu_cls_q, cop_cls_q;
    assign cpu_en_q  = en_q[0];
    assign cop_en_q  = en_q[1];
    assign cpu_cls_q = cls_q[0];
    assign cop_cls_q = cls_q[1];

    // Offsets above the 8-bit map never decode
    always_comb begin
        if ((ADDR_W > 8) && ((bus_addr >> 8) != '0)) sel = SEL_NONE;
        else                                         sel = lic_decode(bus_addr[7:0]);
    end

    always_comb begin
        frc_set_we   = bus_we && (sel == SEL_FRC_SET);
        frc_clr_we   = bus_we && (sel == SEL_FRC_CLR);
        en_set_we[0] = bus_we && (sel == SEL_CPU_EN_SET);
        en_clr_we[0] = bus_we && (sel == SEL_CPU_EN_CLR);
        cls_we[0]    = bus_we && (sel == SEL_CPU_CLS);
        en_set_we[1] = bus_we && (sel == SEL_COP_EN_SET);
        en_clr_we[1] = bus_we && (sel == SEL_COP_EN_CLR);
        cls_we[1]    = bus_we && (sel == SEL_COP_CLS);
    end

    lic_setclr_reg #(.W(LINES)) u_force (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (frc_set_we),
        .clr_we (frc_clr_we),
        .wdata  (bus_wdata),
        .q      (force_q)
    );

    assign pend = irq_lines | force_q;

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        lic_setclr_reg #(.W(LINES)) u_en (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_we (en_set_we[p]),
            .clr_we (en_clr_we[p]),
            .wdata  (bus_wdata),
            .q      (en_q[p])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)         cls_q[p] <= '0;
            else if (cls_we[p]) cls_q[p] <= bus_wdata;
        end

        lic_router #(.W(LINES)) u_route (
            .clk   (clk),
            .rst_n (rst_n),
            .pend  (pend),
            .en    (en_q[p]),
            .cls   (cls_q[p]),
            .irq_o (irq_q[p]),
            .fiq_o (fiq_q[p])
        );
    end

    assign cpu_irq = irq_q[0];
    assign cpu_fiq = fiq_q[0];
    assign cop_irq = irq_q[1];
    assign cop_fiq = fiq_q[1];

    // Read mux: aliases and unmapped offsets return zero
    always_comb begin
        unique case (sel)
            SEL_FIQ_STAT: bus_rdata = pend & en_q[0] & cls_q[0];
            SEL_FRC:      bus_rdata = force_q;
            SEL_CPU_EN:   bus_rdata = en_q[0];
            SEL_CPU_CLS:  bus_rdata = cls_q[0];
            SEL_COP_EN:   bus_rdata = en_q[1];
            SEL_COP_CLS:  bus_rdata = cls_q[1];
            default:      bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lic_bank_chk.sv
module lic_bank_chk #(
    parameter int LINES  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]  bus_wdata,
    input logic [LINES-1:0]  bus_rdata,
    input logic [LINES-1:0]  irq_lines,
    input logic [LINES-1:0]  force_q,
    input logic [LINES-1:0]  cpu_en_q,
    input logic [LINES-1:0]  cop_en_q,
    input logic [LINES-1:0]  cpu_cls_q,
    input logic [LINES-1:0]  cop_cls_q,
    input logic              cpu_irq,
    input logic              cpu_fiq,
    input logic              cop_irq,
    input logic              cop_fiq
);
    logic wr_cpu_set, wr_cpu_clr, wr_frc_clr, wr_cpu_ro, rd_alias;
    assign wr_cpu_set = bus_we && (bus_addr == ADDR_W'(8'h24));
    assign wr_cpu_clr = bus_we && (bus_addr == ADDR_W'(8'h28));
    assign wr_frc_clr = bus_we && (bus_addr == ADDR_W'(8'h1C));
    assign wr_cpu_ro  = bus_we && (bus_addr == ADDR_W'(8'h20));
    assign rd_alias   = (bus_addr == ADDR_W'(8'h18)) || (bus_addr == ADDR_W'(8'h24)) ||
                        (bus_addr == ADDR_W'(8'h34)) || (bus_addr == ADDR_W'(8'h38));

    // R1: first cycle out of reset is quiet
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !(cpu_irq || cpu_fiq || cop_irq || cop_fiq));

    // R2: set alias ORs into the CPU enables
    a_r2_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cpu_set |=> cpu_en_q == ($past(cpu_en_q) | $past(bus_wdata)));

    // R3: all-ones clear disables every CPU line at once
    a_r3_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cpu_clr && (bus_wdata == '1)) |=> cpu_en_q == '0);

    // R7: force bits never drop without a force-clear write
    a_r7_force_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_frc_clr |=> ((force_q & $past(force_q)) == $past(force_q)));

    // R6 / R5: CPU fast request follows last cycle's pending, enabled, class-1 lines
    a_r6_cpu_fiq_timing: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cpu_fiq == |$past((irq_lines | force_q) & cpu_en_q & cpu_cls_q));

    // R11: coprocessor normal request uses only coprocessor masks
    a_r11_cop_irq_own_mask: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cop_irq == |$past((irq_lines | force_q) & cop_en_q & ~cop_cls_q));

    // R10: direct write to the CPU enable offset is ignored
    a_r10_ro_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cpu_ro |=> $stable(cpu_en_q));

    // R9: aliases read as zero
    a_r9_alias_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_alias |-> bus_rdata == '0);
endmodule

bind lic_bank lic_bank_chk #(.LINES(LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .force_q   (force_q),
    .cpu_en_q  (cpu_en_q),
    .cop_en_q  (cop_en_q),
    .cpu_cls_q (cpu_cls_q),
    .cop_cls_q (cop_cls_q),
    .cpu_irq   (cpu_irq),
    .cpu_fiq   (cpu_fiq),
    .cop_irq   (cop_irq),
    .cop_fiq   (cop_fiq)
);

// File: tb/test_lic_bank.sv
`timescale 1ns/1ps
module test_lic_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_irq, cpu_fiq, cop_irq, cop_fiq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lic_bank i_lic_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .cpu_irq   (cpu_irq),
        .cpu_fiq   (cpu_fiq),
        .cop_irq   (cop_irq),
        .cop_fiq   (cop_fiq)
    );

    // Behavioural reference state
    logic [31:0] m_frc, m_en_cpu, m_en_cop, m_cls_cpu, m_cls_cop;
    logic        m_cpu_irq, m_cpu_fiq, m_cop_irq, m_cop_fiq;

    always @(posedge clk) begin
        logic [31:0] p;
        if (!rst_n) begin
            m_frc = 0; m_en_cpu = 0; m_en_cop = 0; m_cls_cpu = 0; m_cls_cop = 0;
            m_cpu_irq = 0; m_cpu_fiq = 0; m_cop_irq = 0; m_cop_fiq = 0;
        end else begin
            p = irq_lines | m_frc;
            m_cpu_irq = (p & m_en_cpu & ~m_cls_cpu) != 0;
            m_cpu_fiq = (p & m_en_cpu &  m_cls_cpu) != 0;
            m_cop_irq = (p & m_en_cop & ~m_cls_cop) != 0;
            m_cop_fiq = (p & m_en_cop &  m_cls_cop) != 0;
            if (bus_we) begin
                case (bus_addr)
                    8'h18: m_frc     = m_frc | bus_wdata;
                    8'h1C: m_frc     = m_frc & ~bus_wdata;
                    8'h24: m_en_cpu  = m_en_cpu | bus_wdata;
                    8'h28: m_en_cpu  = m_en_cpu & ~bus_wdata;
                    8'h2C: m_cls_cpu = bus_wdata;
                    8'h34: m_en_cop  = m_en_cop | bus_wdata;
                    8'h38: m_en_cop  = m_en_cop & ~bus_wdata;
                    8'h3C: m_cls_cop = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h08: return (irq_lines | m_frc) & m_en_cpu & m_cls_cpu;
            8'h14: return m_frc;
            8'h20: return m_en_cpu;
            8'h2C: return m_cls_cpu;
            8'h30: return m_en_cop;
            8'h3C: return m_cls_cop;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Drive one bus cycle at the falling edge, then compare everything.
    task automatic step(input string tag, input logic we, input logic [7:0] a,
                        input logic [31:0] wd, input logic [31:0] lines);
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = wd; irq_lines = lines;
        #1;
        chk(tag, "rdata",   bus_rdata,       model_read(a));
        chk(tag, "cpu_irq", 32'(cpu_irq),    32'(m_cpu_irq));
        chk(tag, "cpu_fiq", 32'(cpu_fiq),    32'(m_cpu_fiq));
        chk(tag, "cop_irq", 32'(cop_irq),    32'(m_cop_irq));
        chk(tag, "cop_fiq", 32'(cop_fiq),    32'(m_cop_fiq));
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] lines);
        step(tag, 1'b0, a, 32'h0, lines);
    endtask

    task automatic wr(input string tag, input logic [7:0] a, input logic [31:0] d, input logic [31:0] lines);
        step(tag, 1'b1, a, d, lines);
    endtask

    function automatic logic [7:0] pick_addr(input logic [3:0] k);
        case (k)
            4'd0: return 8'h08;  4'd1: return 8'h14;  4'd2: return 8'h18;  4'd3: return 8'h1C;
            4'd4: return 8'h20;  4'd5: return 8'h24;  4'd6: return 8'h28;  4'd7: return 8'h2C;
            4'd8: return 8'h30;  4'd9: return 8'h34;  4'd10: return 8'h38; 4'd11: return 8'h3C;
            4'd12: return 8'h24; 4'd13: return 8'h18; 4'd14: return 8'h40; default: return 8'hFC;
        endcase
    endfunction

    initial begin
        logic [31:0] lf;
        // R1: reset holds everything at zero even with lines high
        rst_n = 1'b0;
        rd("R1", 8'h20, 32'hFFFF_FFFF);
        wr("R1", 8'h24, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd("R1", 8'h14, 32'hFFFF_FFFF);
        @(negedge clk); rst_n = 1'b1;
        rd("R1", 8'h20, 32'hFFFF_FFFF);
        rd("R1", 8'h2C, 32'hFFFF_FFFF);
        rd("R1", 8'h30, 32'hFFFF_FFFF);

        // R2: set alias accumulates; zero write changes nothing
        wr("R2", 8'h24, 32'h0000_00F0, 32'h0);
        wr("R2", 8'h24, 32'h0000_0F00, 32'h0);
        wr("R2", 8'h24, 32'h0000_0000, 32'h0);
        rd("R2", 8'h20, 32'h0);

        // R4 / R5 / R6 / R8: class steering on the CPU side
        wr("R4", 8'h2C, 32'h0000_0F00, 32'h0);
        rd("R4", 8'h2C, 32'h0000_0010);
        rd("R5", 8'h08, 32'h0000_0010);
        rd("R6", 8'h08, 32'h0000_0100);
        rd("R8", 8'h08, 32'h0000_0100);
        rd("R8", 8'h08, 32'h0000_0000);

        // R11: coprocessor masks separate from CPU masks
        wr("R11", 8'h34, 32'h0000_0001, 32'h0);
        wr("R11", 8'h3C, 32'h0000_0002, 32'h0);
        rd("R11", 8'h30, 32'h0000_0001);
        rd("R11", 8'h30, 32'h0000_0001);
        wr("R11", 8'h34, 32'h0000_0002, 32'h0000_0002);
        rd("R11", 8'h3C, 32'h0000_0002);
        rd("R11", 8'h3C, 32'h0);

        // R7: force pending sticks while the wire toggles, then clears
        wr("R7", 8'h18, 32'h0000_0020, 32'h0);
        wr("R7", 8'h24, 32'h0000_0020, 32'h0000_0020);
        rd("R7", 8'h14, 32'h0);
        rd("R7", 8'h14, 32'h0000_0020);
        wr("R7", 8'h2C, 32'h0000_0F20, 32'h0);
        rd("R7", 8'h08, 32'h0);
        wr("R7", 8'h1C, 32'h0000_0001, 32'h0);
        rd("R7", 8'h14, 32'h0);
        wr("R7", 8'h1C, 32'h0000_0020, 32'h0);
        rd("R7", 8'h14, 32'h0);
        rd("R7", 8'h08, 32'h0);

        // R3: a single all-ones clear disables every CPU line; coprocessor unaffected
        wr("R3", 8'h28, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd("R3", 8'h20, 32'hFFFF_FFFF);
        rd("R3", 8'h30, 32'hFFFF_FFFF);
        wr("R3", 8'h38, 32'hFFFF_FFFF, 32'h0);
        rd("R3", 8'h30, 32'h0);

        // R10: read-only and unmapped writes are ignored
        wr("R10", 8'h20, 32'hFFFF_FFFF, 32'h0);
        wr("R10", 8'h14, 32'hFFFF_FFFF, 32'h0);
        wr("R10", 8'h08, 32'hFFFF_FFFF, 32'h0);
        wr("R10", 8'h30, 32'hFFFF_FFFF, 32'h0);
        wr("R10", 8'h44, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        rd("R10", 8'h20, 32'hFFFF_FFFF);
        rd("R10", 8'h14, 32'hFFFF_FFFF);
        rd("R10", 8'h30, 32'hFFFF_FFFF);

        // R9: aliases and unmapped offsets read zero
        wr("R9", 8'h24, 32'h0000_FFFF, 32'h0);
        rd("R9", 8'h24, 32'h0);
        rd("R9", 8'h28, 32'h0);
        rd("R9", 8'h1C, 32'h0);
        rd("R9", 8'h38, 32'h0);
        rd("R9", 8'h00, 32'h0);
        rd("R9", 8'hFC, 32'h0);

        // R5 / R6 mixed traffic
        lf = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            step("R5", lf[4], pick_addr(lf[8:5]),
                 {lf[15:0], lf[31:16]} & {8{lf[12:9]}},
                 lf & {lf[7:0], lf[31:8]});
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule